// File: doc/BRIEF.md
# Flash Erase and Protection Manager

This block sits between a command source and a flash array and carries out the three destructive or inspecting commands that do not program data: erasing one page, erasing the whole user space, and checking that the whole user space is blank. It keeps a per-page write-protection register. Protection bits can be added at any time, and are removed only as a side effect of a successful whole-array erase or a passing blank check. In both of those cases nothing is left in the array that needs guarding.

A command is a single-cycle strobe carrying an opcode and a page index. An erase that is allowed raises an erase request toward the array for a fixed, parameterised number of cycles. The duration is the same for one page and for the whole array. An erase that hits protection is refused at once. A refused command raises a sticky refusal flag and the completion pulse, and the block never goes busy. A blank check reads the array through a word read port, one word per cycle, and stops at the first word that is not all ones. While any command runs, further command strobes are dropped.

Top module: `flash_erase_mgr`

## Requirements
- R1: After reset, busy, eraseReq, eraseAll, cmdDone, cmdDenied, blankPass, rdEn and every protBits bit are 0.
- R2: A page erase (cmdOp 2'b01) of an unprotected page below NUM_PAGES holds eraseReq high with eraseAll low and erasePage equal to the requested index for exactly ERASE_CYCLES cycles, starting the cycle after the strobe. Busy covers the same cycles, and cmdDone pulses in the first cycle after busy falls.
- R3: A mass erase (cmdOp 2'b10) holds eraseReq and eraseAll high for exactly ERASE_CYCLES cycles, the same duration as a page erase, and then pulses cmdDone.
- R4: A page erase to a protected page, or to an index of NUM_PAGES or above, never raises busy or eraseReq. cmdDenied and cmdDone are both 1 in the cycle after the strobe, and the array is left unchanged.
- R5: A mass erase is refused in the same way as R4 whenever any protBits bit is 1.
- R6: When a mass erase completes, protBits reads all zeros in the cycle cmdDone is high, including bits that were set while the erase ran.
- R7: A blank check (cmdOp 2'b11) on an array whose words are all ones is busy for exactly NUM_PAGES*WORDS_PER_PAGE cycles. It then shows blankPass 1 and protBits all zeros together with cmdDone.
- R8: A blank check whose first word not all ones is at address k is busy for exactly k+1 cycles. It ends with blankPass 0 and leaves protBits unchanged.
- R9: Command strobes that arrive while busy is high have no effect: no extra busy cycles, no eraseAll, no data change and no later completion.
- R10: cmdDenied stays 1 until denyClr is pulsed and then reads 0. A new refusal sets it again.
- R11: A strobe with cmdOp 2'b00 does nothing: busy and cmdDone stay 0.
- R12: A protSetEn pulse ORs protSetMask into protBits (bit i guards page i). A page erase changes only the words of its own page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 2 | 00 none, 01 page erase, 10 mass erase, 11 blank check |
| cmdPage | input | PAGE_W | Page index for page erase |
| protSetEn | input | 1 | Adds protSetMask to the protection register |
| protSetMask | input | NUM_PAGES | Pages to protect |
| denyClr | input | 1 | Clears the sticky refusal flag |
| rdData | input | WORD_W | Array word at rdAddr, combinational |
| busy | output | 1 | A command is running |
| eraseReq | output | 1 | Erase request to the array |
| eraseAll | output | 1 | Erase request targets the whole array |
| erasePage | output | PAGE_W | Page targeted by eraseReq |
| rdEn | output | 1 | Blank-check read active |
| rdAddr | output | ADDR_W | Word address read during blank check |
| cmdDone | output | 1 | One-cycle completion pulse |
| cmdDenied | output | 1 | Sticky refusal flag |
| blankPass | output | 1 | Result of the last blank check |
| protBits | output | NUM_PAGES | Current protection register |

## Verification
The bench builds the block with six pages of four 16-bit words and a five-cycle erase. Six is not a power of two, so the 3-bit page field can carry indices 6 and 7, and the out-of-range refusal can be driven. A 24-word array keeps a full passing scan short, and an early-exit scan can be placed at a chosen word. Five erase cycles leave room to inject protection bits and stray commands in the middle of an erase and to count its length exactly.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PAGE  = 2'b01,
    OP_MASS  = 2'b10,
    OP_BLANK = 2'b11
  } eraseOp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_SCAN  = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadErase;
    logic massSel;
    logic stepCnt;
    logic startScan;
    logic stepAddr;
    logic clearProt;
    logic markDenied;
    logic markPass;
    logic markFail;
    logic markDone;
  } ctlStrobe_t;

  // conditions reported from datapath to control
  typedef struct packed {
    logic cntZero;
    logic addrLast;
    logic wordBlank;
    logic pageProt;
    logic pageBad;
    logic anyProt;
    logic massLatched;
  } dpStatus_t;

endpackage

// File: rtl/fe_datapath.sv
module fe_datapath
  import flash_erase_pkg::*;
#(
  parameter int NUM_PAGES      = 64,
  parameter int WORDS_PER_PAGE = 256,
  parameter int WORD_W         = 64,
  parameter int ERASE_CYCLES   = 48000,
  localparam int PAGE_W        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int TOTAL_WORDS   = NUM_PAGES * WORDS_PER_PAGE,
  localparam int ADDR_W        = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1,
  localparam int CNT_W         = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [PAGE_W-1:0]    cmdPage,
  input  logic                 protSetEn,
  input  logic [NUM_PAGES-1:0] protSetMask,
  input  logic                 denyClr,
  input  logic [WORD_W-1:0]    rdData,
  output dpStatus_t            status,
  output logic [PAGE_W-1:0]    pageLatch,
  output logic [ADDR_W-1:0]    scanAddr,
  output logic                 doneFlag,
  output logic                 deniedFlag,
  output logic                 passFlag,
  output logic [NUM_PAGES-1:0] protBits
);

  localparam logic [CNT_W-1:0]  CNT_LOAD  = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(TOTAL_WORDS - 1);

  logic [CNT_W-1:0]     cnt;
  logic                 massLatch;
  logic [NUM_PAGES-1:0] pageSel;

  // one-hot decode of the requested page; out-of-range indices select nothing
  always_comb begin
    for (int i = 0; i < NUM_PAGES; i++) begin
      pageSel[i] = (cmdPage == PAGE_W'(i));
    end
  end

  always_comb begin
    status             = '0;
    status.cntZero     = (cnt == '0);
    status.addrLast    = (scanAddr == ADDR_LAST);
    status.wordBlank   = &rdData;
    status.pageBad     = ({1'b0, cmdPage} >= (PAGE_W + 1)'(NUM_PAGES));
    status.pageProt    = |(pageSel & protBits);
    status.anyProt     = |protBits;
    status.massLatched = massLatch;
  end

  // erase timer and target latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      pageLatch <= '0;
      massLatch <= 1'b0;
    end else if (strobe.loadErase) begin
      cnt       <= CNT_LOAD;
      pageLatch <= strobe.massSel ? '0 : cmdPage;
      massLatch <= strobe.massSel;
    end else if (strobe.stepCnt) begin
      cnt <= cnt - 1'b1;
    end
  end

  // blank-check scan address and result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanAddr <= '0;
      passFlag <= 1'b0;
    end else begin
      if (strobe.startScan) begin
        scanAddr <= '0;
        passFlag <= 1'b0;
      end else if (strobe.stepAddr) begin
        scanAddr <= scanAddr + 1'b1;
      end
      if (strobe.markPass) passFlag <= 1'b1;
      else if (strobe.markFail) passFlag <= 1'b0;
    end
  end

  // completion pulse, sticky refusal, protection register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag   <= 1'b0;
      deniedFlag <= 1'b0;
      protBits   <= '0;
    end else begin
      doneFlag <= strobe.markDone;
      if (strobe.markDenied) deniedFlag <= 1'b1;
      else if (denyClr) deniedFlag <= 1'b0;
      if (strobe.clearProt) protBits <= '0;
      else if (protSetEn) protBits <= protBits | protSetMask;
    end
  end

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearProt |=> (protBits == '0));

  p_denied_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (deniedFlag && !denyClr) |=> deniedFlag);

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LOAD);

  p_scan_addr_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    scanAddr <= ADDR_LAST);

endmodule

// File: rtl/fe_control.sv
module fe_control
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       eraseActive,
  output logic       scanActive
);

  ctlState_e state;
  ctlState_e stateNext;
  eraseOp_e  opIn;

  assign opIn = eraseOp_e'(cmdOp);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          unique case (opIn)
            OP_PAGE: begin
              if (status.pageBad || status.pageProt) begin
                strobe.markDenied = 1'b1;
                strobe.markDone   = 1'b1;
              end else begin
                strobe.loadErase = 1'b1;
                strobe.massSel   = 1'b0;
                stateNext        = ST_ERASE;
              end
            end
            OP_MASS: begin
              if (status.anyProt) begin
                strobe.markDenied = 1'b1;
                strobe.markDone   = 1'b1;
              end else begin
                strobe.loadErase = 1'b1;
                strobe.massSel   = 1'b1;
                stateNext        = ST_ERASE;
              end
            end
            OP_BLANK: begin
              strobe.startScan = 1'b1;
              stateNext        = ST_SCAN;
            end
            default: ;
          endcase
        end
      end
      ST_ERASE: begin
        if (status.cntZero) begin
          strobe.markDone  = 1'b1;
          strobe.clearProt = status.massLatched;
          stateNext        = ST_IDLE;
        end else begin
          strobe.stepCnt = 1'b1;
        end
      end
      ST_SCAN: begin
        if (!status.wordBlank) begin
          strobe.markFail = 1'b1;
          strobe.markDone = 1'b1;
          stateNext       = ST_IDLE;
        end else if (status.addrLast) begin
          strobe.markPass  = 1'b1;
          strobe.clearProt = 1'b1;
          strobe.markDone  = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          strobe.stepAddr = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy        = (state != ST_IDLE);
  assign eraseActive = (state == ST_ERASE);
  assign scanActive  = (state == ST_SCAN);

  p_deny_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdValid && cmdOp == 2'b01 && (status.pageBad || status.pageProt))
      |=> (state == ST_IDLE));

  p_hold_erase_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && !status.cntZero) |=> (state == ST_ERASE));

  p_scan_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && !status.wordBlank) |=> (state == ST_IDLE));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && cmdValid) |-> !(strobe.loadErase || strobe.startScan || strobe.markDenied));

  p_noop_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdValid && cmdOp == 2'b00) |=> (state == ST_IDLE));

endmodule

// File: rtl/flash_erase_mgr.sv
module flash_erase_mgr
  import flash_erase_pkg::*;
#(
  parameter int NUM_PAGES      = 64,
  parameter int WORDS_PER_PAGE = 256,
  parameter int WORD_W         = 64,
  parameter int ERASE_CYCLES   = 48000,
  localparam int PAGE_W        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int TOTAL_WORDS   = NUM_PAGES * WORDS_PER_PAGE,
  localparam int ADDR_W        = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [PAGE_W-1:0]    cmdPage,
  input  logic                 protSetEn,
  input  logic [NUM_PAGES-1:0] protSetMask,
  input  logic                 denyClr,
  input  logic [WORD_W-1:0]    rdData,
  output logic                 busy,
  output logic                 eraseReq,
  output logic                 eraseAll,
  output logic [PAGE_W-1:0]    erasePage,
  output logic                 rdEn,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic                 cmdDone,
  output logic                 cmdDenied,
  output logic                 blankPass,
  output logic [NUM_PAGES-1:0] protBits
);

  ctlStrobe_t strobe;
  dpStatus_t  status;
  logic       eraseActive;
  logic       scanActive;

  fe_control uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .status      (status),
    .strobe      (strobe),
    .busy        (busy),
    .eraseActive (eraseActive),
    .scanActive  (scanActive)
  );

  fe_datapath #(
    .NUM_PAGES      (NUM_PAGES),
    .WORDS_PER_PAGE (WORDS_PER_PAGE),
    .WORD_W         (WORD_W),
    .ERASE_CYCLES   (ERASE_CYCLES)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdPage     (cmdPage),
    .protSetEn   (protSetEn),
    .protSetMask (protSetMask),
    .denyClr     (denyClr),
    .rdData      (rdData),
    .status      (status),
    .pageLatch   (erasePage),
    .scanAddr    (rdAddr),
    .doneFlag    (cmdDone),
    .deniedFlag  (cmdDenied),
    .passFlag    (blankPass),
    .protBits    (protBits)
  );

  assign eraseReq = eraseActive;
  assign eraseAll = eraseActive && status.massLatched;
  assign rdEn     = scanActive;

  p_mass_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseAll) |-> ($past(protBits) == '0));

  p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseReq && rdEn));

endmodule

// File: tb/flash_erase_mgr_test.sv
module flash_erase_mgr_test;

  localparam int NP     = 6;
  localparam int WPP    = 4;
  localparam int WW     = 16;
  localparam int EC     = 5;
  localparam int TOTAL  = NP * WPP;
  localparam int PW     = 3;
  localparam int AW     = 5;
  localparam logic [WW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdOp = 2'b00;
  logic [PW-1:0] cmdPage = '0;
  logic          protSetEn = 1'b0;
  logic [NP-1:0] protSetMask = '0;
  logic          denyClr = 1'b0;
  logic [WW-1:0] rdData;
  logic          busy, eraseReq, eraseAll, rdEn, cmdDone, cmdDenied, blankPass;
  logic [PW-1:0] erasePage;
  logic [AW-1:0] rdAddr;
  logic [NP-1:0] protBits;

  logic [WW-1:0] mem [TOTAL];
  logic          fillEn = 1'b0;
  int            fillAddr = 0;
  logic [WW-1:0] fillVal = '0;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  flash_erase_mgr #(
    .NUM_PAGES(NP), .WORDS_PER_PAGE(WPP), .WORD_W(WW), .ERASE_CYCLES(EC)
  ) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPage(cmdPage),
    .protSetEn(protSetEn), .protSetMask(protSetMask), .denyClr(denyClr), .rdData(rdData),
    .busy(busy), .eraseReq(eraseReq), .eraseAll(eraseAll), .erasePage(erasePage),
    .rdEn(rdEn), .rdAddr(rdAddr), .cmdDone(cmdDone), .cmdDenied(cmdDenied),
    .blankPass(blankPass), .protBits(protBits)
  );

  // array model: erase requests and bench-side programming
  assign rdData = (int'(rdAddr) < TOTAL) ? mem[rdAddr] : ONES;

  always @(posedge clk) begin
    if (eraseReq) begin
      for (int i = 0; i < TOTAL; i++) begin
        if (eraseAll || (i / WPP) == int'(erasePage)) mem[i] <= ONES;
      end
    end else if (fillEn) begin
      mem[fillAddr] <= fillVal;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeWord(input int addr, input logic [WW-1:0] val);
    @(negedge clk);
    fillEn = 1'b1; fillAddr = addr; fillVal = val;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic fillPattern();
    for (int i = 0; i < TOTAL; i++) writeWord(i, WW'(i * 3));
  endtask

  task automatic fillOnes();
    for (int i = 0; i < TOTAL; i++) writeWord(i, ONES);
  endtask

  task automatic setProt(input logic [NP-1:0] mask);
    @(negedge clk);
    protSetEn = 1'b1; protSetMask = mask;
    @(negedge clk);
    protSetEn = 1'b0;
  endtask

  // issues a command and follows it to completion; optional injection in busy cycle 2
  task automatic runCmd(input logic [1:0] op, input logic [PW-1:0] pg,
                        input logic injCmd, input logic [1:0] injOp,
                        input logic [NP-1:0] injProt,
                        output int busyCyc, output int reqCyc,
                        output int sawAll, output int lastPage, output int doneAfter);
    busyCyc = 0; reqCyc = 0; sawAll = 0; lastPage = -1;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPage = pg;
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy && busyCyc < 1000) begin
      busyCyc++;
      if (eraseReq) begin
        reqCyc++;
        if (eraseAll) sawAll = 1;
        lastPage = int'(erasePage);
      end
      if (busyCyc == 2) begin
        cmdValid = injCmd; cmdOp = injOp; cmdPage = '0;
        protSetEn = |injProt; protSetMask = injProt;
      end
      @(negedge clk);
      cmdValid = 1'b0; protSetEn = 1'b0;
    end
    doneAfter = int'(cmdDone);
  endtask

  task automatic testReset();
    check("R1 busy", int'(busy), 0);
    check("R1 eraseReq", int'(eraseReq | eraseAll), 0);
    check("R1 done/denied", int'({cmdDone, cmdDenied}), 0);
    check("R1 blankPass/rdEn", int'({blankPass, rdEn}), 0);
    check("R1 protBits", int'(protBits), 0);
  endtask

  task automatic testProtSet();
    setProt(6'b000100);
    check("R12 prot set", int'(protBits), 6'b000100);
    setProt(6'b100000);
    check("R12 prot OR", int'(protBits), 6'b100100);
  endtask

  task automatic testPageErase();
    int b, r, a, p, d;
    runCmd(2'b01, 3'd1, 1'b0, 2'b00, '0, b, r, a, p, d);
    check("R2 busy cycles", b, EC);
    check("R2 request cycles", r, EC);
    check("R2 eraseAll low", a, 0);
    check("R2 target page", p, 1);
    check("R2 done pulse", d, 1);
    @(negedge clk);
    check("R2 done one cycle", int'(cmdDone), 0);
    for (int i = 4; i < 8; i++) check("R2 page words ones", int'(mem[i] == ONES), 1);
    check("R12 page0 untouched", int'(mem[3]), 9);
    check("R12 page2 untouched", int'(mem[8]), 24);
  endtask

  task automatic testDenyProt();
    int b, r, a, p, d;
    runCmd(2'b01, 3'd2, 1'b0, 2'b00, '0, b, r, a, p, d);
    check("R4 protected busy", b, 0);
    check("R4 protected no req", r, 0);
    check("R4 protected done", d, 1);
    check("R4 protected denied", int'(cmdDenied), 1);
    check("R4 protected data kept", int'(mem[9]), 27);
  endtask

  task automatic testDenyRange();
    int b, r, a, p, d;
    @(negedge clk); denyClr = 1'b1;
    @(negedge clk); denyClr = 1'b0;
    runCmd(2'b01, 3'd7, 1'b0, 2'b00, '0, b, r, a, p, d);
    check("R4 range busy", b, 0);
    check("R4 range no req", r, 0);
    check("R4 range denied+done", int'({cmdDenied, cmdDone}), 3);
  endtask

  task automatic testSticky();
    repeat (3) @(negedge clk);
    check("R10 denied holds", int'(cmdDenied), 1);
    denyClr = 1'b1;
    @(negedge clk);
    denyClr = 1'b0;
    check("R10 denied cleared", int'(cmdDenied), 0);
  endtask

  task automatic testMassDenied();
    int b, r, a, p, d;
    runCmd(2'b10, 3'd0, 1'b0, 2'b00, '0, b, r, a, p, d);
    check("R5 mass busy", b, 0);
    check("R5 mass no req", r, 0);
    check("R5 mass denied", int'({cmdDenied, cmdDone}), 3);
    check("R5 data kept", int'(mem[0]), 0);
    check("R5 prot kept", int'(protBits), 6'b100100);
  endtask

  task automatic testNoop();
    int b, r, a, p, d;
    runCmd(2'b00, 3'd0, 1'b0, 2'b00, '0, b, r, a, p, d);
    check("R11 noop busy", b, 0);
    check("R11 noop done", d, 0);
  endtask

  task automatic testBlankPass();
    int b, r, a, p, d;
    fillOnes();
    runCmd(2'b11, 3'd0, 1'b0, 2'b00, '0, b, r, a, p, d);
    check("R7 scan cycles", b, TOTAL);
    check("R7 done", d, 1);
    check("R7 blankPass", int'(blankPass), 1);
    check("R7 protection cleared", int'(protBits), 0);
  endtask

  task automatic testMassOk();
    int b, r, a, p, d;
    fillPattern();
    runCmd(2'b10, 3'd0, 1'b0, 2'b00, 6'b010000, b, r, a, p, d);
    check("R3 mass busy cycles", b, EC);
    check("R3 mass request cycles", r, EC);
    check("R3 eraseAll seen", a, 1);
    check("R3 done", d, 1);
    check("R6 prot cleared at done", int'(protBits), 0);
    check("R3 first word ones", int'(mem[0] == ONES), 1);
    check("R3 last word ones", int'(mem[TOTAL-1] == ONES), 1);
  endtask

  task automatic testBlankFail();
    int b, r, a, p, d;
    writeWord(10, 16'h00F0);
    setProt(6'b000010);
    runCmd(2'b11, 3'd0, 1'b0, 2'b00, '0, b, r, a, p, d);
    check("R8 scan stops early", b, 11);
    check("R8 done", d, 1);
    check("R8 blankPass low", int'(blankPass), 0);
    check("R8 prot kept", int'(protBits), 6'b000010);
  endtask

  task automatic testBusyIgnore();
    int b, r, a, p, d;
    fillPattern();
    runCmd(2'b01, 3'd0, 1'b1, 2'b10, '0, b, r, a, p, d);
    check("R9 busy unchanged", b, EC);
    check("R9 no mass", a, 0);
    check("R9 done", d, 1);
    runCmd(2'b01, 3'd3, 1'b1, 2'b11, '0, b, r, a, p, d);
    check("R9 busy unchanged scan", b, EC);
    check("R9 target page", p, 3);
    repeat (2) @(negedge clk);
    check("R9 no late busy", int'(busy), 0);
    check("R9 no late done", int'(cmdDone), 0);
    check("R9 page5 kept", int'(mem[20]), 60);
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    for (int i = 0; i < TOTAL; i++) mem[i] = WW'(i * 3);
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testProtSet();
        testPageErase();
        testDenyProt();
        testDenyRange();
        testSticky();
        testMassDenied();
        testNoop();
        testBlankPass();
        testMassOk();
        testBlankFail();
        testBusyIgnore();
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    if (timedOut) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule